// File: doc/BRIEF.md
# Dual Loop Code Detector

This block watches a received serial bit stream for two repeating patterns at once. One pattern is the loop-up code and the other is the loop-down code. Each pattern has its own 16-bit definition and its own 3-bit length select. For each pattern, a matcher runs a bit-phase counter, a mismatch counter and a window timer. The window timer counts qualified bits, which are the clock cycles with `bitEn` high. A matcher that reaches the end of a window with few enough mismatches sets its sticky flag. A matcher that sees too many mismatches slides its alignment by one bit and starts a new window, so an unaligned stream is found without outside help.

The window length and the mismatch allowance are parameters. With the default values, the window is 48 ms of a 1.544 Mb/s stream and the allowance is 2 % of the window. With that allowance the detector still locks at a bit error ratio of one in a hundred. Software reads the two flags, clears them with the clear strobes, and decides how long a code has to persist.

Top module: `dual_loop_code_detector`

## Requirements
- R1: The up matcher and the down matcher run independently. Each uses only its own definition and length select, and drives only its own flag.
- R2: Length select decoding: 001 gives 3 bits, 010 gives 5, 011 gives 6 and 100 gives 7. The codes 000, 101, 110 and 111 give 16 bits, and 16-bit mode also carries periods of 1, 2, 4 and 8. A pattern of length L is bits [15:16-L] of the definition, and bit 15 is the first bit of the pattern in time.
- R3: Take an error-free stream whose first qualified bit after reset is pattern bit 15. The flag is still low after WINDOW_BITS-1 qualified bits and is high after WINDOW_BITS qualified bits.
- R4: A window that contains at most ERR_LIMIT mismatches still sets the flag at the end of that window.
- R5: In the qualified bit where the mismatch count of the current window first exceeds ERR_LIMIT, the window is abandoned. The pattern phase does not advance in that bit, and a new window starts. As a result, a window with ERR_LIMIT+1 errors does not set the flag, and a stream that starts at any phase is eventually found.
- R6: A set flag stays high until its clear strobe. A pulse on the clear strobe drops the flag in the next cycle. If the code is still present, the flag sets again at the end of the next window, which is WINDOW_BITS qualified bits after the previous set.
- R7: In cycles with `bitEn` low, no phase, counter or flag changes except through a clear strobe. All timing is counted in qualified bits.
- R8: A synchronous reset clears both flags, both phases and all counters. After reset, the R3 timing holds again from the first qualified bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Marks a cycle that carries a received bit |
| rxBit | input | 1 | Received bit, sampled when bitEn is high |
| upCode | input | 16 | Loop-up pattern definition |
| upLenSel | input | 3 | Loop-up length select |
| dnCode | input | 16 | Loop-down pattern definition |
| dnLenSel | input | 3 | Loop-down length select |
| upClr | input | 1 | Clear strobe for upFlag |
| dnClr | input | 1 | Clear strobe for dnFlag |
| upFlag | output | 1 | Sticky loop-up detected flag |
| dnFlag | output | 1 | Sticky loop-down detected flag |

## Verification
The phase-range assertion assumes that a length select changes only in a cycle where it is allowed to move the phase out of range. It therefore checks the range only while the select is stable. The stimulus writes definitions and length selects only while reset is held, and keeps them fixed for a whole run. The stimulus sends a bit only with `bitEn` high. Some runs put idle cycles between the bits to show that timing counts qualified bits and not clocks. Clear strobes are issued in idle cycles, so a clear and a window end never fall in the same cycle.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int PAT_W   = 16;
  localparam int PHASE_W = $clog2(PAT_W);
  localparam int LEN_W   = PHASE_W + 1;

  typedef struct packed {
    logic step;     // qualified bit consumed, phase advances
    logic slip;     // too many mismatches, phase held, window restarts
    logic passWin;  // window finished within the error allowance
  } lcdStrobe_t;

  function automatic logic [LEN_W-1:0] decodeLen(input logic [2:0] sel);
    case (sel)
      3'b001:  return LEN_W'(3);
      3'b010:  return LEN_W'(5);
      3'b011:  return LEN_W'(6);
      3'b100:  return LEN_W'(7);
      default: return LEN_W'(PAT_W);
    endcase
  endfunction
endpackage

// File: rtl/lcd_match_ctrl.sv
module lcd_match_ctrl
  import lcd_pkg::*;
#(
  parameter int WINDOW_BITS = 74112,
  parameter int ERR_LIMIT   = 1482
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitEn,
  input  logic       mismatch,
  output lcdStrobe_t stb
);
  localparam int CNT_W = $clog2(WINDOW_BITS);
  localparam int ERR_W = $clog2(ERR_LIMIT + 2);

  logic [CNT_W-1:0] bitCnt;
  logic [ERR_W-1:0] errCnt;
  logic [ERR_W-1:0] errNext;
  logic             overLimit;
  logic             lastBit;

  always_comb begin
    errNext     = errCnt + ERR_W'(mismatch);
    overLimit   = bitEn && (errNext > ERR_W'(ERR_LIMIT));
    lastBit     = bitEn && (bitCnt == CNT_W'(WINDOW_BITS - 1));
    stb.step    = bitEn && !overLimit;
    stb.slip    = overLimit;
    stb.passWin = lastBit && !overLimit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      errCnt <= '0;
    end else if (overLimit || lastBit) begin
      bitCnt <= '0;
      errCnt <= '0;
    end else if (bitEn) begin
      bitCnt <= bitCnt + 1'b1;
      errCnt <= errNext;
    end
  end

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
    errCnt <= ERR_W'(ERR_LIMIT)); // R4
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= CNT_W'(WINDOW_BITS - 1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> ($stable(bitCnt) && $stable(errCnt))); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (bitCnt == '0 && errCnt == '0)); // R8
endmodule

// File: rtl/lcd_match_path.sv
module lcd_match_path
  import lcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rxBit,
  input  logic [PAT_W-1:0] codeDef,
  input  logic [2:0]       lenSel,
  input  logic             clr,
  input  lcdStrobe_t       stb,
  output logic             mismatch,
  output logic             flag
);
  logic [PHASE_W-1:0] phase;
  logic [LEN_W-1:0]   patLen;
  logic               expBit;
  logic               wrapNow;

  always_comb begin
    patLen   = decodeLen(lenSel);
    expBit   = codeDef[PHASE_W'(PAT_W - 1) - phase];
    mismatch = rxBit ^ expBit;
    wrapNow  = ({1'b0, phase} >= patLen - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (stb.step) begin
      phase <= wrapNow ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (stb.passWin) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    ($stable(lenSel) && ({1'b0, $past(phase)} < $past(patLen)))
      |-> ({1'b0, phase} < patLen)); // R2
  AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    stb.slip |=> $stable(phase)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && !stb.passWin) |=> !flag); // R6
endmodule

// File: rtl/dual_loop_code_detector.sv
module dual_loop_code_detector
  import lcd_pkg::*;
#(
  parameter int WINDOW_BITS = 74112,
  parameter int ERR_LIMIT   = WINDOW_BITS / 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bitEn,
  input  logic        rxBit,
  input  logic [15:0] upCode,
  input  logic [2:0]  upLenSel,
  input  logic [15:0] dnCode,
  input  logic [2:0]  dnLenSel,
  input  logic        upClr,
  input  logic        dnClr,
  output logic        upFlag,
  output logic        dnFlag
);
  localparam int NUM_CODES = 2;

  logic [NUM_CODES-1:0][PAT_W-1:0] codeDefs;
  logic [NUM_CODES-1:0][2:0]       lenSels;
  logic [NUM_CODES-1:0]            clrs;
  logic [NUM_CODES-1:0]            flags;

  assign codeDefs = {dnCode, upCode};
  assign lenSels  = {dnLenSel, upLenSel};
  assign clrs     = {dnClr, upClr};
  assign upFlag   = flags[0];
  assign dnFlag   = flags[1];

  for (genvar gi = 0; gi < NUM_CODES; gi++) begin : gMatch
    lcdStrobe_t stb;
    logic       mismatch;

    lcd_match_ctrl #(
      .WINDOW_BITS(WINDOW_BITS),
      .ERR_LIMIT  (ERR_LIMIT)
    ) uCtrl (
      .clk     (clk),
      .rst     (rst),
      .bitEn   (bitEn),
      .mismatch(mismatch),
      .stb     (stb)
    );

    lcd_match_path uPath (
      .clk     (clk),
      .rst     (rst),
      .rxBit   (rxBit),
      .codeDef (codeDefs[gi]),
      .lenSel  (lenSels[gi]),
      .clr     (clrs[gi]),
      .stb     (stb),
      .mismatch(mismatch),
      .flag    (flags[gi])
    );

    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[gi]) |-> $past(bitEn)); // R7
  end
endmodule

// File: tb/dual_loop_code_detector_test.sv
module dual_loop_code_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 64;
  localparam int LIM = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitEn = 1'b0;
  logic rxBit = 1'b0;
  logic [15:0] upCode = '0;
  logic [15:0] dnCode = '0;
  logic [2:0] upLenSel = '0;
  logic [2:0] dnLenSel = '0;
  logic upClr = 1'b0;
  logic dnClr = 1'b0;
  logic upFlag, dnFlag;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // stream state
  logic [15:0] srcDef;
  int srcLen;
  int sentBits;
  int offs;
  int errAt[3];
  bit gapMode;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_loop_code_detector #(.WINDOW_BITS(WIN), .ERR_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .bitEn(bitEn), .rxBit(rxBit),
    .upCode(upCode), .upLenSel(upLenSel), .dnCode(dnCode), .dnLenSel(dnLenSel),
    .upClr(upClr), .dnClr(dnClr), .upFlag(upFlag), .dnFlag(dnFlag));

  function automatic int lenOf(input int c);
    case (c)
      1: return 3;
      2: return 5;
      3: return 6;
      4: return 7;
      default: return 16;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (bit %0d)", req, act, exp, sentBits);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; bitEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    sentBits = 0;
    errAt[0] = -1; errAt[1] = -1; errAt[2] = -1;
  endtask

  // drives one qualified bit at a negedge; returns at a later negedge
  task automatic sendBit();
    logic b;
    b = srcDef[15 - ((sentBits + offs) % srcLen)];
    if (sentBits == errAt[0] || sentBits == errAt[1] || sentBits == errAt[2]) b = ~b;
    rxBit = b; bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    sentBits++;
    if (gapMode) begin
      rxBit = ~rxBit;
      @(negedge clk);
    end
  endtask

  task automatic sendN(input int n);
    for (int i = 0; i < n; i++) sendBit();
  endtask

  task automatic setup(input logic [15:0] uc, input int ul, input logic [15:0] dc, input int dl,
                       input int off);
    upCode = uc; upLenSel = 3'(ul); dnCode = dc; dnLenSel = 3'(dl);
    srcDef = uc; srcLen = lenOf(ul); offs = off;
    doReset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    gapMode = 0;
    offs = 0; srcDef = 16'h8000; srcLen = 5; sentBits = 0;
    errAt[0] = -1; errAt[1] = -1; errAt[2] = -1;
    doReset();
    // R8 reset state
    check("R8 reset upFlag", upFlag, 1'b0);
    check("R8 reset dnFlag", dnFlag, 1'b0);

    // R2 R3 R7 sweep over every length code, both matchers loaded identically
    for (int lc = 0; lc < 8; lc++) begin
      logic [15:0] d;
      d = 16'hB38E ^ 16'(lc * 16'h1357);
      gapMode = lc[0];
      setup(d, lc, d, lc, 0);
      sendN(WIN - 1);
      check("R3 up not before window", upFlag, 1'b0);
      check("R3 dn not before window", dnFlag, 1'b0);
      sendBit();
      check("R2 up set at window end", upFlag, 1'b1);
      check("R7 dn set at window end (qualified bits)", dnFlag, 1'b1);
    end
    gapMode = 0;

    // R1 R2: down code is a shifted reading of the same 5-bit loop
    setup(16'h8000, 2, 16'h0800, 2, 0);
    sendN(WIN);
    check("R1 up set", upFlag, 1'b1);
    check("R1 dn not set by other code", dnFlag, 1'b0);

    // R4: exactly LIM errors in the window
    setup(16'h8000, 2, 16'hE000, 1, 0);
    errAt[0] = 10; errAt[1] = 20;
    sendN(WIN);
    check("R4 set with limit errors", upFlag, 1'b1);
    check("R1 dn 3-bit code idle", dnFlag, 1'b0);

    // R5: LIM+1 errors abandon the window, lock is regained later
    setup(16'h8000, 2, 16'hE000, 1, 0);
    errAt[0] = 10; errAt[1] = 20; errAt[2] = 30;
    sendN(WIN);
    check("R5 no set with excess errors", upFlag, 1'b0);
    while (!upFlag && sentBits < 4 * WIN) sendBit();
    check("R5 relock after slip", upFlag, 1'b1);

    // R5: stream starting at every wrong phase of a 7-bit code
    for (int o = 1; o < 7; o++) begin
      setup(16'hD200, 4, 16'h0000, 0, o);
      sendN(WIN);
      check("R5 misaligned not set at first window", upFlag, 1'b0);
      while (!upFlag && sentBits < 4 * WIN) sendBit();
      check("R5 misaligned found", upFlag, 1'b1);
    end

    // R6: clear and re-set one window later, sticky while code stops
    gapMode = 1;
    setup(16'h8000, 2, 16'h8000, 2, 0);
    sendN(WIN);
    check("R6 set before clear", upFlag, 1'b1);
    sendN(5);
    upClr = 1'b1;
    @(negedge clk);
    upClr = 1'b0;
    check("R6 cleared by strobe", upFlag, 1'b0);
    check("R6 other flag kept", dnFlag, 1'b1);
    sendN(WIN - 6);
    check("R6 not set before next window", upFlag, 1'b0);
    sendBit();
    check("R6 set again after next window", upFlag, 1'b1);
    srcDef = 16'h0000; srcLen = 16;
    sendN(20);
    check("R6 sticky after code stops", upFlag, 1'b1);
    gapMode = 0;

    // R7: idle cycles with toggling data change nothing
    for (int i = 0; i < 30; i++) begin
      rxBit = i[0];
      @(negedge clk);
    end
    check("R7 idle keeps flag", upFlag, 1'b1);

    // R8: reset mid-run, timing restarts
    setup(16'h8000, 2, 16'h8000, 2, 0);
    check("R8 flags cleared", upFlag, 1'b0);
    sendN(WIN - 1);
    check("R8 timer cleared", upFlag, 1'b0);
    sendBit();
    check("R8 set after full window", upFlag, 1'b1);

    summary();
  end
endmodule